// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Manipulation Unit

This block is the purely combinational datapath behind the prefixed bit-operation group of an 8-bit CPU. A two-bit class field picks one of four operation families: rotate/shift, test a bit, clear a bit, or set a bit. A three-bit selector then names either the rotate/shift variant or the bit position. The operand and the incoming flag nibble enter on the same cycle. The result and the updated flags are available combinationally.

The surrounding core fetches the operand from a register or memory and writes the result back. It also owns instruction timing. This unit only computes values. It holds no state of its own and has no internal states or transitions. A caller may therefore sample its outputs in the same cycle it presents its inputs.

Top module: `bitu_core`

## Requirements
- R1: `cls_i` selects the family: 2'b00 rotate/shift, 2'b01 bit test, 2'b10 bit clear, 2'b11 bit set. Both flag ports are packed as {Z, N, H, C} in bits 3 down to 0.
- R2: In the rotate/shift class, sel 0 rotates left circularly and sel 1 rotates right circularly. The bit that leaves the operand enters at the opposite end and is also copied into C.
- R3: Sel 2 rotates left through carry and sel 3 rotates right through carry. The vacated end takes the incoming C, and the bit that leaves becomes the new C.
- R4: Sel 4 shifts left. Bit 0 becomes 0 and the old bit 7 goes to C.
- R5: Sel 5 shifts right arithmetically. Bit 7 keeps its value and the old bit 0 goes to C.
- R6: Sel 7 shifts right logically. Bit 7 becomes 0 and the old bit 0 goes to C.
- R7: Sel 6 exchanges the upper and lower nibbles and clears C.
- R8: Every rotate/shift variant clears N and H, and sets Z exactly when the 8-bit result is zero.
- R9: Bit test sets Z when bit `sel_i` of the operand is 0, sets H, clears N and passes C through. The result port carries the operand unchanged.
- R10: Bit clear forces bit `sel_i` to 0, leaves every other bit alone and returns the incoming flags unchanged.
- R11: Bit set forces bit `sel_i` to 1, leaves every other bit alone and returns the incoming flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 2 | Operation family |
| sel_i | input | 3 | Rotate/shift variant or bit index |
| opnd_i | input | 8 | Operand value |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| result_o | output | 8 | Computed value |
| flags_o | output | 4 | Updated flags {Z,N,H,C} |

## Verification
The bench builds the unit with its default width of 8 bits. This makes the nibble boundary at bit 4 and every bit index from 0 to 7 reachable through the 3-bit selector. Within that width, every rotate/shift variant is driven with both carry values, including operands 0x00, 0x01, 0x80 and 0xFF, where the departing bit and the zero flag reach their extremes. The bit-edit families are exercised on all eight indices, using operands where the addressed bit is already in its target state.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLEAR = 2'b10,
        CLS_SET   = 2'b11
    } cls_e;

    typedef enum logic [2:0] {
        SH_ROL_CIRC  = 3'd0,
        SH_ROR_CIRC  = 3'd1,
        SH_ROL_CARRY = 3'd2,
        SH_ROR_CARRY = 3'd3,
        SH_LEFT      = 3'd4,
        SH_RIGHT_ARI = 3'd5,
        SH_NIB_SWAP  = 3'd6,
        SH_RIGHT_LOG = 3'd7
    } shift_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/bitu_shifter.sv
module bitu_shifter
    import bitu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shift_op_e         op_i,
    input  logic [DATA_W-1:0] d_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] q_o,
    output flags_t            fl_o
);
    localparam int HALF_W = DATA_W / 2;

    logic msb, lsb, c_out;

    always_comb begin
        msb   = d_i[DATA_W-1];
        lsb   = d_i[0];
        q_o   = d_i;
        c_out = 1'b0;
        unique case (op_i)
            SH_ROL_CIRC: begin
                q_o   = {d_i[DATA_W-2:0], msb};
                c_out = msb;
            end
            SH_ROR_CIRC: begin
                q_o   = {lsb, d_i[DATA_W-1:1]};
                c_out = lsb;
            end
            SH_ROL_CARRY: begin
                q_o   = {d_i[DATA_W-2:0], c_i};
                c_out = msb;
            end
            SH_ROR_CARRY: begin
                q_o   = {c_i, d_i[DATA_W-1:1]};
                c_out = lsb;
            end
            SH_LEFT: begin
                q_o   = {d_i[DATA_W-2:0], 1'b0};
                c_out = msb;
            end
            SH_RIGHT_ARI: begin
                q_o   = {msb, d_i[DATA_W-1:1]};
                c_out = lsb;
            end
            SH_NIB_SWAP: begin
                q_o   = {d_i[HALF_W-1:0], d_i[DATA_W-1:HALF_W]};
                c_out = 1'b0;
            end
            SH_RIGHT_LOG: begin
                q_o   = {1'b0, d_i[DATA_W-1:1]};
                c_out = lsb;
            end
        endcase
        fl_o.z = (q_o == '0);
        fl_o.n = 1'b0;
        fl_o.h = 1'b0;
        fl_o.c = c_out;

        // R2: circular rotates neither create nor lose set bits
        if (op_i == SH_ROL_CIRC || op_i == SH_ROR_CIRC)
            assert_circ_keeps_ones_R2: assert ($countones(q_o) == $countones(d_i));
        // R7: swap keeps the population of ones
        if (op_i == SH_NIB_SWAP)
            assert_swap_keeps_ones_R7: assert ($countones(q_o) == $countones(d_i));
    end

endmodule

// File: rtl/bitu_bitops.sv
module bitu_bitops
    import bitu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  cls_e              cls_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] d_i,
    input  flags_t            fl_i,
    output logic [DATA_W-1:0] q_o,
    output flags_t            fl_o
);
    logic [DATA_W-1:0] mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (idx_i == IDX_W'(g));
    end

    always_comb begin
        q_o  = d_i;
        fl_o = fl_i;
        unique case (cls_i)
            CLS_SHIFT: begin
                q_o  = d_i;
                fl_o = fl_i;
            end
            CLS_TEST: begin
                q_o    = d_i;
                fl_o.z = ~|(d_i & mask);
                fl_o.n = 1'b0;
                fl_o.h = 1'b1;
                fl_o.c = fl_i.c;
            end
            CLS_CLEAR: q_o = d_i & ~mask;
            CLS_SET:   q_o = d_i | mask;
        endcase

        // R10/R11: an edit touches at most one bit
        if (cls_i == CLS_CLEAR || cls_i == CLS_SET)
            assert_single_bit_edit_R10: assert ($countones(q_o ^ d_i) <= 1);
    end

endmodule

// File: rtl/bitu_core.sv
module bitu_core
    import bitu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        cls_i,
    input  logic [2:0]        sel_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    cls_e              cls;
    flags_t            fl_in;
    logic [DATA_W-1:0] sh_q, bo_q;
    flags_t            sh_fl, bo_fl;

    assign cls   = cls_e'(cls_i);
    assign fl_in = flags_t'(flags_i);

    bitu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op_i (shift_op_e'(sel_i)),
        .d_i  (opnd_i),
        .c_i  (fl_in.c),
        .q_o  (sh_q),
        .fl_o (sh_fl)
    );

    bitu_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bits (
        .cls_i (cls),
        .idx_i (IDX_W'(sel_i)),
        .d_i   (opnd_i),
        .fl_i  (fl_in),
        .q_o   (bo_q),
        .fl_o  (bo_fl)
    );

    always_comb begin
        unique case (cls)
            CLS_SHIFT: begin
                result_o = sh_q;
                flags_o  = sh_fl;
            end
            CLS_TEST, CLS_CLEAR, CLS_SET: begin
                result_o = bo_q;
                flags_o  = bo_fl;
            end
        endcase

        // R8: shift group clears N and H and reports zero
        if (cls == CLS_SHIFT)
            assert_shift_flags_R8: assert (flags_o[2:1] == 2'b00 &&
                                           flags_o[3] == (result_o == '0));
        // R9: test keeps the operand and the carry, forces H
        if (cls == CLS_TEST)
            assert_test_preserves_R9: assert (result_o == opnd_i &&
                                              flags_o[0] == flags_i[0] && flags_o[1]);
        // R11: edits leave the flags untouched
        if (cls == CLS_CLEAR || cls == CLS_SET)
            assert_edit_flags_kept_R11: assert (flags_o == flags_i);
        // R7: swap clears carry
        if (cls == CLS_SHIFT && sel_i == 3'd6)
            assert_swap_clears_c_R7: assert (flags_o[0] == 1'b0);
    end

endmodule

// File: tb/bitu_core_tb_top.sv
`timescale 1ns/1ps
module bitu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cls;
    logic [2:0] sel;
    logic [7:0] opnd;
    logic [3:0] flg;
    logic [7:0] res;
    logic [3:0] flo;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bitu_core dut_i (
        .cls_i    (cls),
        .sel_i    (sel),
        .opnd_i   (opnd),
        .flags_i  (flg),
        .result_o (res),
        .flags_o  (flo)
    );

    logic [7:0] pats [6] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C};

    // independent model, returns {flags, result}
    function automatic logic [11:0] model(input logic [1:0] c, input logic [2:0] s,
                                          input logic [7:0] d, input logic [3:0] f);
        logic [7:0] r;
        logic [3:0] o;
        logic       cy;
        r = d; o = f; cy = 1'b0;
        if (c == 2'b00) begin
            case (s)
                3'd0: begin r = 8'((d << 1) | (d >> 7)); cy = d[7]; end
                3'd1: begin r = 8'((d >> 1) | (d << 7)); cy = d[0]; end
                3'd2: begin r = 8'((d << 1) | 8'(f[0])); cy = d[7]; end
                3'd3: begin r = 8'((d >> 1) | (8'(f[0]) << 7)); cy = d[0]; end
                3'd4: begin r = 8'(d << 1); cy = d[7]; end
                3'd5: begin r = 8'((d >> 1) | (d & 8'h80)); cy = d[0]; end
                3'd6: begin r = 8'((d << 4) | (d >> 4)); cy = 1'b0; end
                default: begin r = 8'(d >> 1); cy = d[0]; end
            endcase
            o = {(r == 8'h00), 1'b0, 1'b0, cy};
        end else if (c == 2'b01) begin
            r = d;
            o = {~d[s], 1'b0, 1'b1, f[0]};
        end else if (c == 2'b10) begin
            for (int i = 0; i < 8; i++) if (i == int'(s)) r[i] = 1'b0;
        end else begin
            for (int i = 0; i < 8; i++) if (i == int'(s)) r[i] = 1'b1;
        end
        return {o, r};
    endfunction

    task automatic drive(input logic [1:0] c, input logic [2:0] s,
                         input logic [7:0] d, input logic [3:0] f);
        @(posedge clk);
        cls = c; sel = s; opnd = d; flg = f;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: cls=%0d sel=%0d op=%h fl=%h got flags=%h res=%h exp flags=%h res=%h",
                     req, cls, sel, opnd, flg, got[11:8], got[7:0], exp[11:8], exp[7:0]);
        end
    endtask

    task automatic run_one(input string req, input logic [1:0] c, input logic [2:0] s,
                           input logic [7:0] d, input logic [3:0] f);
        drive(c, s, d, f);
        check(req, {flo, res}, model(c, s, d, f));
    endtask

    task automatic t_idle;
        drive(2'b00, 3'd0, 8'h00, 4'h0);
        check("R8 idle", {flo, res}, {4'b1000, 8'h00});
    endtask

    task automatic t_sweep_shift(input string req, input logic [2:0] s);
        foreach (pats[i]) begin
            run_one(req, 2'b00, s, pats[i], 4'b0000);
            run_one(req, 2'b00, s, pats[i], 4'b0111);
        end
    endtask

    task automatic t_fixed_values;
        drive(2'b00, 3'd0, 8'h80, 4'h0); check("R2 rlc 80", {flo, res}, {4'b0001, 8'h01});
        drive(2'b00, 3'd1, 8'h01, 4'h0); check("R2 rrc 01", {flo, res}, {4'b0001, 8'h80});
        drive(2'b00, 3'd2, 8'h80, 4'h0); check("R3 rl 80 c0", {flo, res}, {4'b1001, 8'h00});
        drive(2'b00, 3'd3, 8'h00, 4'h1); check("R3 rr 00 c1", {flo, res}, {4'b0000, 8'h80});
        drive(2'b00, 3'd4, 8'hFF, 4'hE); check("R4 sla ff", {flo, res}, {4'b0001, 8'hFE});
        drive(2'b00, 3'd5, 8'h81, 4'h0); check("R5 sra 81", {flo, res}, {4'b0001, 8'hC0});
        drive(2'b00, 3'd7, 8'h81, 4'h0); check("R6 srl 81", {flo, res}, {4'b0001, 8'h40});
        drive(2'b00, 3'd6, 8'hA5, 4'hF); check("R7 swap a5", {flo, res}, {4'b0000, 8'h5A});
        drive(2'b00, 3'd6, 8'h00, 4'hF); check("R7 swap 00", {flo, res}, {4'b1000, 8'h00});
    endtask

    task automatic t_bit_family(input string req, input logic [1:0] c);
        for (int b = 0; b < 8; b++) begin
            run_one(req, c, 3'(b), 8'h00, 4'b0000);
            run_one(req, c, 3'(b), 8'hFF, 4'b1111);
            run_one(req, c, 3'(b), 8'(1 << b), 4'b0101);
            run_one(req, c, 3'(b), ~8'(1 << b), 4'b1010);
        end
    endtask

    task automatic t_class_select;
        drive(2'b01, 3'd3, 8'hF7, 4'h1); check("R1 test", {flo, res}, {4'b1011, 8'hF7});
        drive(2'b10, 3'd3, 8'hFF, 4'h6); check("R1 clear", {flo, res}, {4'h6, 8'hF7});
        drive(2'b11, 3'd3, 8'h00, 4'h9); check("R1 set", {flo, res}, {4'h9, 8'h08});
        drive(2'b00, 3'd3, 8'h08, 4'h1); check("R1 shift", {flo, res}, {4'b0000, 8'h84});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cls = 2'b00; sel = 3'd0; opnd = 8'h00; flg = 4'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_fixed_values();
        t_sweep_shift("R2", 3'd0);
        t_sweep_shift("R2", 3'd1);
        t_sweep_shift("R3", 3'd2);
        t_sweep_shift("R3", 3'd3);
        t_sweep_shift("R4", 3'd4);
        t_sweep_shift("R5", 3'd5);
        t_sweep_shift("R7", 3'd6);
        t_sweep_shift("R6", 3'd7);
        t_bit_family("R9", 2'b01);
        t_bit_family("R10", 2'b10);
        t_bit_family("R11", 2'b11);
        t_class_select();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule